// File: doc/BRIEF.md
# Memory Region Attribute Table

This block keeps two attribute flags, cacheable and prefetchable, for every 16 MB region of a 32-bit address space. A request on the lookup port presents an address. One cycle later the block returns whether that region may be cached and whether it may be prefetched. Caches and prefetch engines sitting beside a core use it as their policy source.

Software reads and writes the table one region at a time through a word-indexed register port. Each region word exposes the cacheable flag in bit 0 and the prefetchable flag in bit 3. Every other bit position is discarded on writes and reads back as zero. The lowest sixteen regions describe internal memories and are fixed: writes to them change nothing. Regions 0 to 14 return constants chosen by parameter. Region 15 is pinned to prefetch-only. The remaining regions come out of reset as prefetch-only and can be reprogrammed freely.

Top module: `region_attr_table`

## Requirements
- R1: The table has 256 entries, and a lookup address selects the entry given by its bits [31:24], so each entry covers 16 MB (for example 0xE0000000–0xE0FFFFFF maps to entry 224).
- R2: When `lk_valid_i` is high, `lk_valid_o` is high in the next cycle together with that entry's flags (`lk_cache_o` = bit 0, `lk_pref_o` = bit 3). When `lk_valid_o` is low, both flags are low.
- R3: A read (`reg_en_i` high, `reg_we_i` low) returns the entry on `reg_rdata_o` in the next cycle, with cacheable in bit 0, prefetchable in bit 3, and all other bits zero.
- R4: On a write, only bits 0 and 3 of `reg_wdata_i` are stored. All other bit positions are discarded, so writing 0xFFFFFFFF reads back 0x00000009.
- R5: Writes to entries 0 through 15 are ignored, as seen on both the readback and the lookup ports.
- R6: Entries 0–14 hold parameter constants (default: cacheable only, word 0x00000001). Entry 15 always holds prefetch-only (0x00000008).
- R7: After reset, entries 16–255 read 0x00000008 (prefetch on, caching off).
- R8: Writing 0x00000009 to a writable entry enables both flags, and writing 0x00000000 clears both. A lookup presented in the cycle after the write sees the new value. A lookup presented in the same cycle as the write sees the old value.
- R9: `reg_rdata_o` holds its value in every cycle that has no read.
- R10: During and right after reset, `lk_valid_o`, `lk_cache_o`, `lk_pref_o` and `reg_rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_idx_i | input | 8 | Entry index (word address) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after a read |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup address |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_cache_o | output | 1 | Region is cacheable |
| lk_pref_o | output | 1 | Region is prefetchable |

## Verification
If an entry's stored flags are wrong, the error shows up on `lk_cache_o` or `lk_pref_o` in the cycle after any lookup that hits that region. It also shows up on `reg_rdata_o` one cycle after a read of that entry. A write decode that strays into the fixed region would alter a low-region lookup in the very next cycle. A stored reserved bit would appear as a nonzero bit outside positions 0 and 3 on the next readback. The bench keeps a behavioural copy of the table and compares all four outputs every cycle, so a divergence is caught within one cycle of the first access that exposes it.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;
  localparam int unsigned CACHE_BIT = 0;
  localparam int unsigned PREF_BIT  = 3;
  localparam int unsigned WORD_W    = 32;

  typedef struct packed {
    logic pref;
    logic cache;
  } attr_t;

  function automatic logic [WORD_W-1:0] attr_to_word(attr_t a);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CACHE_BIT] = a.cache;
    w[PREF_BIT]  = a.pref;
    return w;
  endfunction

  function automatic attr_t word_to_attr(logic [WORD_W-1:0] w);
    attr_t a;
    a.cache = w[CACHE_BIT];
    a.pref  = w[PREF_BIT];
    return a;
  endfunction
endpackage

// File: rtl/region_attr_store.sv
module region_attr_store
  import region_attr_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 256,
  parameter int unsigned NUM_RO   = 16,
  parameter logic [NUM_RO-2:0] RO_CACHE = '1,
  parameter logic [NUM_RO-2:0] RO_PREF  = '0,
  localparam int unsigned IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  attr_t            wr_attr_i,
  output logic [NUM_ENT-1:0] cache_vec_o,
  output logic [NUM_ENT-1:0] pref_vec_o
);
  localparam logic [IDX_W-1:0] RO_LIM = IDX_W'(NUM_RO);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    if (g < NUM_RO - 1) begin : g_fixed
      assign cache_vec_o[g] = RO_CACHE[g];
      assign pref_vec_o[g]  = RO_PREF[g];
    end else if (g == NUM_RO - 1) begin : g_edge
      // last internal region: pinned prefetch-only
      assign cache_vec_o[g] = 1'b0;
      assign pref_vec_o[g]  = 1'b1;
    end else begin : g_rw
      logic cache_q, pref_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cache_q <= 1'b0;
          pref_q  <= 1'b1;
        end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
          cache_q <= wr_attr_i.cache;
          pref_q  <= wr_attr_i.pref;
        end
      end
      assign cache_vec_o[g] = cache_q;
      assign pref_vec_o[g]  = pref_q;
    end
  end

  // R8: a write to a writable entry lands in the next cycle
  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i >= RO_LIM) |=>
      (cache_vec_o[$past(wr_idx_i)] == $past(wr_attr_i.cache) &&
       pref_vec_o[$past(wr_idx_i)]  == $past(wr_attr_i.pref)));
endmodule

// File: rtl/region_attr_lookup.sv
module region_attr_lookup #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_ENT = 256,
  localparam int unsigned IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [ADDR_W-1:0]  lk_addr_i,
  input  logic [NUM_ENT-1:0] cache_vec_i,
  input  logic [NUM_ENT-1:0] pref_vec_i,
  output logic               lk_valid_o,
  output logic               lk_cache_o,
  output logic               lk_pref_o
);
  logic [IDX_W-1:0] idx;
  logic unused_lo;
  assign idx = lk_addr_i[ADDR_W-1 -: IDX_W];
  assign unused_lo = ^lk_addr_i[ADDR_W-IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_cache_o <= 1'b0;
      lk_pref_o  <= 1'b0;
    end else begin
      lk_valid_o <= lk_valid_i;
      lk_cache_o <= lk_valid_i & cache_vec_i[idx];
      lk_pref_o  <= lk_valid_i & pref_vec_i[idx];
    end
  end

  p_lk_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_o |-> (!lk_cache_o && !lk_pref_o));
endmodule

// File: rtl/region_attr_readback.sv
module region_attr_readback
  import region_attr_pkg::*;
#(
  parameter int unsigned NUM_ENT = 256,
  localparam int unsigned IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic [NUM_ENT-1:0] cache_vec_i,
  input  logic [NUM_ENT-1:0] pref_vec_i,
  output logic [WORD_W-1:0]  rdata_o
);
  attr_t sel;
  assign sel = '{pref: pref_vec_i[rd_idx_i], cache: cache_vec_i[rd_idx_i]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= attr_to_word(sel);
  end

  localparam logic [WORD_W-1:0] RSVD_MASK =
    ~((WORD_W'(1) << CACHE_BIT) | (WORD_W'(1) << PREF_BIT));

  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & RSVD_MASK) == '0);
  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/region_attr_table.sv
module region_attr_table
  import region_attr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_ENT = 256,
  parameter int unsigned NUM_RO  = 16,
  parameter logic [NUM_RO-2:0] RO_CACHE = '1,
  parameter logic [NUM_RO-2:0] RO_PREF  = '0,
  localparam int unsigned IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_valid_o,
  output logic              lk_cache_o,
  output logic              lk_pref_o
);
  localparam logic [IDX_W-1:0] RO_LIM = IDX_W'(NUM_RO);

  logic [NUM_ENT-1:0] cache_vec, pref_vec;
  logic wr_en, rd_en;
  attr_t wr_attr;
  logic unused_rsvd;

  assign wr_en   = reg_en_i & reg_we_i & (reg_idx_i >= RO_LIM);
  assign rd_en   = reg_en_i & ~reg_we_i;
  assign wr_attr = word_to_attr(reg_wdata_i);
  assign unused_rsvd = ^reg_wdata_i;

  region_attr_store #(
    .NUM_ENT(NUM_ENT), .NUM_RO(NUM_RO), .RO_CACHE(RO_CACHE), .RO_PREF(RO_PREF)
  ) i_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(reg_idx_i), .wr_attr_i(wr_attr),
    .cache_vec_o(cache_vec), .pref_vec_o(pref_vec)
  );

  region_attr_lookup #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) i_lookup (
    .clk_i, .rst_ni,
    .lk_valid_i, .lk_addr_i,
    .cache_vec_i(cache_vec), .pref_vec_i(pref_vec),
    .lk_valid_o, .lk_cache_o, .lk_pref_o
  );

  region_attr_readback #(.NUM_ENT(NUM_ENT)) i_readback (
    .clk_i, .rst_ni,
    .rd_en_i(rd_en), .rd_idx_i(reg_idx_i),
    .cache_vec_i(cache_vec), .pref_vec_i(pref_vec),
    .rdata_o(reg_rdata_o)
  );

  // R5: a lookup of a fixed region never reflects a write
  p_fixed_lookup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_addr_i[ADDR_W-1 -: IDX_W] == RO_LIM - 1'b1) |=>
      (!lk_cache_o && lk_pref_o));
  // R8: write then lookup of the same entry in the next cycle returns new data
  p_wr_then_lk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && reg_we_i && reg_idx_i >= RO_LIM) ##1
    (lk_valid_i && lk_addr_i[ADDR_W-1 -: IDX_W] == $past(reg_idx_i) &&
     !(reg_en_i && reg_we_i)) |=>
      (lk_cache_o == $past(reg_wdata_i[CACHE_BIT], 2) &&
       lk_pref_o  == $past(reg_wdata_i[PREF_BIT], 2)));
endmodule

// File: tb/test_region_attr_table.sv
module test_region_attr_table;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_v_o, lk_c_o, lk_p_o;

  int checks = 0, errors = 0;
  int mem [256];
  logic exp_v = 0, exp_c = 0, exp_p = 0;
  logic [31:0] exp_rd = '0;
  bit done = 0;

  always #4 clk = ~clk;

  region_attr_table i_region_attr_table (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
    .lk_valid_o(lk_v_o), .lk_cache_o(lk_c_o), .lk_pref_o(lk_p_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) mem[i] = (i < 15) ? 32'h1 : 32'h8;
    exp_v = 0; exp_c = 0; exp_p = 0; exp_rd = '0;
  endfunction

  // reference model: outputs after each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int li;
      li = int'(lk_addr >> 24);
      exp_v = lk_valid;
      exp_c = lk_valid & mem[li][0];
      exp_p = lk_valid & mem[li][3];
      if (reg_en && !reg_we) exp_rd = mem[reg_idx];
      if (reg_en && reg_we && reg_idx >= 16) mem[reg_idx] = reg_wdata & 32'h9;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 lk_valid", {31'b0, lk_v_o}, {31'b0, exp_v});
      chk("R1 lk_cache", {31'b0, lk_c_o}, {31'b0, exp_c});
      chk("R1 lk_pref",  {31'b0, lk_p_o}, {31'b0, exp_p});
      chk("R3 rdata",    reg_rdata, exp_rd);
    end
  end

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_idx = 8'(idx);
    @(negedge clk);
    reg_en = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_idx = 8'(idx); reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic lk(input logic [31:0] a, input logic c, input logic p, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
    chk(tag, {30'b0, lk_p_o, lk_c_o}, {30'b0, p, c});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    // R10 reset state
    chk("R10 rdata", reg_rdata, 32'h0);
    chk("R10 lk", {29'b0, lk_v_o, lk_c_o, lk_p_o}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 after", {reg_rdata[3:0], 1'b0, lk_v_o, lk_c_o, lk_p_o}, 32'h0);

    // R7 reset values and R6 fixed entries
    for (int i = 0; i < 256; i++)
      rd(i, (i < 15) ? 32'h1 : 32'h8, (i < 16) ? "R6 fixed" : "R7 reset");

    // R5 writes to fixed entries ignored
    wr(3, 32'h0); wr(15, 32'h9); wr(0, 32'hFFFF_FFFF);
    rd(3, 32'h1, "R5 ro3"); rd(15, 32'h8, "R5 ro15"); rd(0, 32'h1, "R5 ro0");
    lk(32'h0F12_3456, 1'b0, 1'b1, "R5 lk15");
    lk(32'h0300_0000, 1'b1, 1'b0, "R5 lk3");

    // R4 reserved bits discarded
    wr(100, 32'hFFFF_FFFF); rd(100, 32'h9, "R4 all ones");
    wr(101, 32'hFFFF_FFF6); rd(101, 32'h0, "R4 only rsvd");

    // R8 enable/disable, next-cycle visibility
    wr(224, 32'h9); lk(32'hE0FF_FFFF, 1'b1, 1'b1, "R8 en");
    lk(32'hE100_0000, 1'b0, 1'b1, "R1 neighbour");
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_idx = 8'd224; reg_wdata = 32'h0;
    lk_valid = 1; lk_addr = 32'hE000_0000;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
    chk("R8 same cycle old", {30'b0, lk_p_o, lk_c_o}, 32'h3);
    @(negedge clk);
    lk_valid = 0;
    chk("R8 next cycle new", {30'b0, lk_p_o, lk_c_o}, 32'h0);

    // R9 hold
    rd(16, 32'h8, "R9 seed");
    repeat (5) @(negedge clk);
    chk("R9 hold", reg_rdata, 32'h8);

    // mixed traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      reg_en    = $urandom_range(0, 1);
      reg_we    = $urandom_range(0, 1);
      reg_idx   = 8'($urandom_range(0, 3) == 0 ? $urandom_range(0, 20) : $urandom_range(0, 255));
      reg_wdata = $urandom();
      lk_valid  = $urandom_range(0, 1);
      lk_addr   = {($urandom_range(0, 1) ? reg_idx : 8'($urandom_range(0, 255))), 24'($urandom())};
    end
    @(negedge clk);
    reg_en = 0; lk_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule